// File: doc/BRIEF.md
# Audio Transmit FIFO Register and Interrupt Unit

This block is the bus side of a playback-only audio serial controller. Software sees a small file of 32-bit word-aligned registers. It can read an identification word, set a configuration word whose fields go straight to the serializer, and choose which of two interrupt causes may raise the interrupt line. It can read the live interrupt cause bits, and it pushes sample words into a transmit FIFO through any of four write-only data addresses.

The serializer takes words from the FIFO through a show-ahead pop port. Two words form one stereo frame. The unit tracks two live conditions on the FIFO fill. One flags that the FIFO is empty. The other flags that the fill has fallen below a threshold of `FIFO_DEPTH >> level`, where `level` is a field of the configuration word. Each condition is masked, and the result is gated by a global interrupt enable to produce one interrupt output. Serial bit timing and clock division are handled elsewhere, and this block only supplies their settings.

Top module: `audio_txfifo_regs`

## Requirements
- R1: After reset the configuration word and the mask read as zero, the FIFO is empty (`ser_empty`=1), the status register reads 3, and `irq` is 0.
- R2: A read of byte offset 0x00 returns the `VERSION` parameter, and a write to 0x00 has no effect on it.
- R3: A write to offset 0x04 stores all 32 bits, which read back unchanged. The field outputs come from fixed positions: bit 0 `cfg_tx_en`, bit 1 interrupt enable, bit 2 `cfg_left`, bits 15:8 `cfg_ratio`, bits 21:16 `cfg_res`, bits 27:24 `cfg_level`, bits 31:28 `cfg_chan`.
- R4: The mask at offset 0x08 keeps only bits 1:0 of a write. Bit 0 enables the underrun cause and bit 1 enables the low-level cause. Bits 31:2 read as zero.
- R5: A write to any of offsets 0x10, 0x14, 0x18 or 0x1C pushes the write data as one FIFO word. Reads of these offsets return zero.
- R6: The FIFO returns words in write order, with the head word visible on `ser_data` before the pop. A pop while the FIFO is empty changes nothing.
- R7: A data write while the FIFO holds `FIFO_DEPTH` words is dropped. The stored words and their order are unchanged, and no status bit records the drop.
- R8: Status bit 0 (underrun), read at offset 0x0C, is 1 exactly when the FIFO is empty.
- R9: Status bit 1 (low level) is 1 exactly when the fill is less than `FIFO_DEPTH >> cfg_level`.
- R10: Writes to the status offset 0x0C are accepted but change neither the status nor anything else.
- R11: `irq` is 1 when interrupt enable is set and the status ANDed with the mask is non-zero. With `IRQ_REG`=1, `irq` follows that condition one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ser_pop | input | 1 | Serializer takes the head word |
| ser_data | output | 32 | Head word of the FIFO |
| ser_empty | output | 1 | FIFO holds no word |
| cfg_tx_en | output | 1 | Transmit enable field |
| cfg_left | output | 1 | Left-channel-first flag field |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_level | output | 4 | FIFO threshold shift field |
| cfg_chan | output | 4 | Channel field |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with a 16-word FIFO and the registered interrupt variant. With 16 words, a full FIFO, a dropped overflow write and a complete wrap of both pointers each take only a few dozen cycles. Level values 0, 1 and 2 then put the threshold at 16, 8 and 4 words. The low-level bit can therefore be checked on both sides of each threshold, including level 0, where the bit is set whenever the FIFO is not full.

// File: rtl/atx_pkg.sv
package atx_pkg;

   localparam int REG_W = 32;

   // byte offsets of the register file
   localparam int OFF_VER   = 'h00;
   localparam int OFF_CFG   = 'h04;
   localparam int OFF_MASK  = 'h08;
   localparam int OFF_STAT  = 'h0C;
   localparam int OFF_DATA0 = 'h10;

   // cause bit positions shared by status and mask
   localparam int CAUSE_UNDER = 0;
   localparam int CAUSE_LOW   = 1;
   localparam int CAUSE_W     = 2;

   typedef struct packed {
      logic [3:0] chan;
      logic [3:0] level;
      logic [1:0] rsv_hi;
      logic [5:0] res;
      logic [7:0] ratio;
      logic [4:0] rsv_lo;
      logic       left;
      logic       int_en;
      logic       tx_en;
   } cfg_t;

endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
   parameter int DEPTH = 1024,
   parameter int W     = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);

   initial begin
      assert (DEPTH >= 4 && (1 << AW) == DEPTH)
         else $error("atx_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> ($stable(wr_ptr) && full));

   assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop) |=> $stable(rd_ptr));

   assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((count >= $past(count)) ? (count - $past(count)) : ($past(count) - count)) <= CW'(1));

endmodule

// File: rtl/atx_regfile.sv
module atx_regfile
   import atx_pkg::*;
#(
   parameter int              ADDR_W   = 5,
   parameter int              NUM_DATA = 4,
   parameter logic [REG_W-1:0] VERSION = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [CAUSE_W-1:0] status,
   output cfg_t               cfg,
   output logic [CAUSE_W-1:0] mask,
   output logic               push,
   output logic [REG_W-1:0]   push_data
);

   localparam int SPAN = OFF_DATA0 + 4 * NUM_DATA;

   initial begin
      assert (NUM_DATA >= 1 && SPAN <= (1 << ADDR_W))
         else $error("atx_regfile: data registers do not fit in ADDR_W");
   end

   localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFF_VER);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

   logic [NUM_DATA-1:0] data_hit;

   for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
      localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA0 + 4 * i);
      assign data_hit[i] = reg_wr && (reg_addr == A_DATA);
   end

   assign push      = |data_hit;
   assign push_data = reg_wdata;

   logic cfg_we, mask_we;
   assign cfg_we  = reg_wr && (reg_addr == A_CFG);
   assign mask_we = reg_wr && (reg_addr == A_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg  <= '0;
         mask <= '0;
      end else begin
         if (cfg_we)  cfg  <= cfg_t'(reg_wdata);
         if (mask_we) mask <= reg_wdata[CAUSE_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_VER)       reg_rdata = VERSION;
      else if (reg_addr == A_CFG)  reg_rdata = REG_W'(cfg);
      else if (reg_addr == A_MASK) reg_rdata = REG_W'(mask);
      else if (reg_addr == A_STAT) reg_rdata = REG_W'(status);
   end

   assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg));

   assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask));

   assert_push_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(data_hit));

endmodule

// File: rtl/atx_irq.sv
module atx_irq
   import atx_pkg::*;
#(
   parameter int DEPTH   = 1024,
   parameter bit IRQ_REG = 1'b1,
   localparam int CW     = $clog2(DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CW-1:0]      count,
   input  logic [3:0]         level,
   input  logic [CAUSE_W-1:0] mask,
   input  logic               int_en,
   output logic [CAUSE_W-1:0] status,
   output logic               irq
);

   logic [CW-1:0] thresh;
   logic          irq_d;

   assign thresh              = CW'(DEPTH) >> level;
   assign status[CAUSE_UNDER] = (count == '0);
   assign status[CAUSE_LOW]   = (count < thresh);
   assign irq_d               = int_en && |(status & mask);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq = irq_q;

      assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !int_en |=> !irq);
   end else begin : g_irq_comb
      assign irq = irq_d;

      assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !int_en |-> !irq);
   end

   assert_under_implies_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[CAUSE_UNDER] && level < 4'(CW - 1)) |-> status[CAUSE_LOW]);

endmodule

// File: rtl/audio_txfifo_regs.sv
module audio_txfifo_regs
   import atx_pkg::*;
#(
   parameter int               FIFO_DEPTH = 1024,
   parameter int               ADDR_W     = 5,
   parameter int               NUM_DATA   = 4,
   parameter bit               IRQ_REG    = 1'b1,
   parameter logic [REG_W-1:0] VERSION    = 32'h0000_0100,
   localparam int              CW         = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              ser_pop,
   output logic [31:0]       ser_data,
   output logic              ser_empty,
   output logic              cfg_tx_en,
   output logic              cfg_left,
   output logic [7:0]        cfg_ratio,
   output logic [5:0]        cfg_res,
   output logic [3:0]        cfg_level,
   output logic [3:0]        cfg_chan,
   output logic              irq
);

   cfg_t               cfg;
   logic [CAUSE_W-1:0] mask, status;
   logic               push, full;
   logic [REG_W-1:0]   push_data;
   logic [CW-1:0]      count;

   atx_regfile #(
      .ADDR_W   (ADDR_W),
      .NUM_DATA (NUM_DATA),
      .VERSION  (VERSION)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .status    (status),
      .cfg       (cfg),
      .mask      (mask),
      .push      (push),
      .push_data (push_data)
   );

   atx_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (REG_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (ser_pop),
      .head      (ser_data),
      .empty     (ser_empty),
      .full      (full),
      .count     (count)
   );

   atx_irq #(
      .DEPTH   (FIFO_DEPTH),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (count),
      .level  (cfg.level),
      .mask   (mask),
      .int_en (cfg.int_en),
      .status (status),
      .irq    (irq)
   );

   assign cfg_tx_en = cfg.tx_en;
   assign cfg_left  = cfg.left;
   assign cfg_ratio = cfg.ratio;
   assign cfg_res   = cfg.res;
   assign cfg_level = cfg.level;
   assign cfg_chan  = cfg.chan;

   assert_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status[CAUSE_UNDER] == ser_empty);

   assert_full_not_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !status[CAUSE_LOW]);

endmodule

// File: tb/tb_audio_txfifo_regs.sv
module tb_audio_txfifo_regs;

   localparam int          DEPTH = 16;
   localparam logic [31:0] VER   = 32'h0001_0203;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ser_pop = 1'b0;
   logic [31:0] ser_data;
   logic        ser_empty, cfg_tx_en, cfg_left, irq;
   logic [7:0]  cfg_ratio;
   logic [5:0]  cfg_res;
   logic [3:0]  cfg_level, cfg_chan;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   audio_txfifo_regs #(
      .FIFO_DEPTH (DEPTH),
      .ADDR_W     (5),
      .NUM_DATA   (4),
      .IRQ_REG    (1'b1),
      .VERSION    (VER)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .ser_pop (ser_pop), .ser_data (ser_data), .ser_empty (ser_empty),
      .cfg_tx_en (cfg_tx_en), .cfg_left (cfg_left), .cfg_ratio (cfg_ratio),
      .cfg_res (cfg_res), .cfg_level (cfg_level), .cfg_chan (cfg_chan), .irq (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all primitives start and end at a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pop_chk(input string req, input logic [31:0] exp);
      #1 chk(req, ser_data, exp);
      ser_pop = 1'b1;
      @(negedge clk);
      ser_pop = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(5'h04, v); chk("R1 cfg", v, 0);
      rd(5'h08, v); chk("R1 mask", v, 0);
      rd(5'h0C, v); chk("R1 status", v, 3);
      chk("R1 empty", 32'(ser_empty), 1);
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_version;
      logic [31:0] v;
      rd(5'h00, v); chk("R2 version", v, VER);
      wr(5'h00, 32'h1234_5678);
      rd(5'h00, v); chk("R2 version after write", v, VER);
   endtask

   task automatic t_config;
      logic [31:0] v;
      wr(5'h04, 32'h932A_C507);
      rd(5'h04, v); chk("R3 readback", v, 32'h932A_C507);
      chk("R3 tx_en", 32'(cfg_tx_en), 1);
      chk("R3 left", 32'(cfg_left), 1);
      chk("R3 ratio", 32'(cfg_ratio), 32'hC5);
      chk("R3 res", 32'(cfg_res), 32'h2A);
      chk("R3 level", 32'(cfg_level), 3);
      chk("R3 chan", 32'(cfg_chan), 9);
      wr(5'h04, 32'h0);
      rd(5'h04, v); chk("R3 cleared", v, 0);
   endtask

   task automatic t_mask;
      logic [31:0] v;
      wr(5'h08, 32'hFFFF_FFFF);
      rd(5'h08, v); chk("R4 mask bits", v, 3);
      wr(5'h08, 32'h0);
   endtask

   task automatic t_order;
      logic [31:0] v;
      for (int i = 0; i < 5; i++) wr(5'(5'h10 + 4 * (i % 4)), 32'hA000_0000 + i);
      rd(5'h10, v); chk("R5 data read zero", v, 0);
      rd(5'h1C, v); chk("R5 data read zero hi", v, 0);
      for (int i = 0; i < 5; i++) pop_chk("R6 order", 32'hA000_0000 + i);
      #1 chk("R6 empty after drain", 32'(ser_empty), 1);
      ser_pop = 1'b1; @(negedge clk); ser_pop = 1'b0;
      #1 chk("R6 pop on empty", 32'(ser_empty), 1);
      wr(5'h14, 32'h0000_BEEF);
      #1 chk("R6 head after empty pop", ser_data, 32'h0000_BEEF);
      pop_chk("R6 single", 32'h0000_BEEF);
   endtask

   task automatic t_full;
      logic [31:0] v;
      for (int i = 0; i < DEPTH; i++) wr(5'h18, 32'hC000_0000 + i);
      rd(5'h0C, v); chk("R9 full not low", v, 0);
      wr(5'h10, 32'hDEAD_DEAD);
      rd(5'h0C, v); chk("R7 no status on drop", v, 0);
      for (int i = 0; i < DEPTH; i++) pop_chk("R7 contents kept", 32'hC000_0000 + i);
      #1 chk("R7 nothing extra", 32'(ser_empty), 1);
      rd(5'h0C, v); chk("R8 underrun when empty", v, 3);
   endtask

   task automatic t_level;
      logic [31:0] v;
      wr(5'h04, 32'h0100_0000);              // level 1 -> threshold 8
      for (int i = 0; i < 7; i++) wr(5'h10, i);
      rd(5'h0C, v); chk("R9 7 below 8", v, 2);
      wr(5'h10, 7);
      rd(5'h0C, v); chk("R9 8 not below 8", v, 0);
      wr(5'h04, 32'h0200_0000);              // level 2 -> threshold 4
      rd(5'h0C, v); chk("R9 8 vs 4", v, 0);
      wr(5'h04, 32'h0000_0000);              // level 0 -> threshold 16
      rd(5'h0C, v); chk("R9 8 vs 16", v, 2);
      rd(5'h0C, v); chk("R8 not empty", 32'(v[0]), 0);
   endtask

   task automatic t_status_wr;
      logic [31:0] v;
      wr(5'h0C, 32'hFFFF_FFFF);
      rd(5'h0C, v); chk("R10 status write ignored", v, 2);
      rd(5'h04, v); chk("R10 cfg untouched", v, 0);
      rd(5'h08, v); chk("R10 mask untouched", v, 0);
      #1 chk("R10 fifo untouched", ser_data, 0);
   endtask

   task automatic t_irq;   // fifo holds 8 words 0..7 on entry
      wr(5'h08, 32'h3);
      idle(2); chk("R11 gated off", 32'(irq), 0);
      wr(5'h04, 32'h0100_0002);              // int enable, level 1
      idle(2); chk("R11 at threshold", 32'(irq), 0);
      pop_chk("R11 pop", 0);
      idle(2); chk("R11 low raises", 32'(irq), 1);
      wr(5'h08, 32'h1);
      idle(2); chk("R11 underrun only", 32'(irq), 0);
      for (int i = 1; i < 8; i++) pop_chk("R11 drain", i);
      idle(2); chk("R11 underrun raises", 32'(irq), 1);
      wr(5'h04, 32'h0100_0000);
      idle(2); chk("R11 disable drops", 32'(irq), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_version();
      t_config();
      t_mask();
      t_order();
      t_full();
      t_level();
      t_status_wr();
      t_irq();
      idle(2);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule